// File: doc/BRIEF.md
# Predicated Gather Prefetch Address Sequencer

This block takes one vector gather-prefetch operation and turns it into a series of prefetch requests, one for each lane that the governing predicate marks as active. An operation carries a vector of lane elements, a byte-granular predicate, an element-size select (32-bit or 64-bit lanes), a 5-bit unsigned immediate and a 4-bit prefetch code. Each request carries a 64-bit byte address, a read/write hint, a target cache level and a streaming flag.

The operation is accepted through a valid/ready handshake and is registered on acceptance. The sequencer then walks the active lanes from lowest to highest index. It presents one request at a time on a second valid/ready handshake and skips inactive lanes without spending a cycle on them. A one-cycle done pulse marks the end of the operation.

Top module: `gpf_seq`

## Requirements
- R1: The address of a request is the lane element, zero-extended to 64 bits, plus the immediate multiplied by 8 (0 to 248). The sum wraps modulo 2^64.
- R2: When `opWide` is 0 the vector holds VEC_BITS/32 lanes of 32 bits, with lane i at bits [32i+31:32i]. When `opWide` is 1 it holds VEC_BITS/64 lanes of 64 bits, with lane i at bits [64i+63:64i].
- R3: A lane produces a request only if its predicate bit is set. For 32-bit lanes that bit is `opPred[4i]`, and for 64-bit lanes it is `opPred[8i]`. All other predicate bits are ignored.
- R4: Requests for active lanes are issued in ascending lane order.
- R5: The request hint comes from `opCode`. `reqWrite` is bit 3 (0 means read, 1 means write), `reqLevel` is bits 2:1, and `reqStream` is bit 0 (1 means streaming, 0 means temporal).
- R6: While `reqValid` is high and `reqReady` is low, the request and all its fields stay unchanged. The sequencer moves to the next lane only on a completed handshake.
- R7: `opDone` is high for exactly one cycle, and never together with `reqValid`. It comes in the cycle after the final request handshake. When no lane is active, it comes in the cycle after acceptance and no request is issued.
- R8: `opReady` is high only while the block is idle, which excludes the busy cycles and the done cycle. While `opReady` is low, `opValid` has no effect. Operation inputs may change freely after acceptance without affecting the requests.
- R9: After synchronous active-high reset, `opReady` is 1 and both `reqValid` and `opDone` are 0.
- R10: With `reqReady` held high, active lanes issue in consecutive cycles whatever the gaps between them, and `reqValid` is high in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | Operation offered |
| opReady | output | 1 | Block idle and able to accept |
| opVector | input | VEC_BITS | Lane elements (base addresses) |
| opPred | input | VEC_BITS/8 | Governing predicate, one bit per byte |
| opWide | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| opImm | input | 5 | Unsigned immediate, scaled by 8 |
| opCode | input | 4 | Prefetch code: write, level, stream |
| reqValid | output | 1 | Prefetch request valid |
| reqReady | input | 1 | Request accepted by consumer |
| reqAddr | output | 64 | Request byte address |
| reqWrite | output | 1 | Write (store) intent hint |
| reqLevel | output | 2 | Target cache level |
| reqStream | output | 1 | Streaming (non-temporal) hint |
| opDone | output | 1 | One-cycle end-of-operation pulse |

## Verification
The hardest case to reach is a back-pressured request whose next active lane lies past a run of inactive lanes, with the operation inputs scrambled underneath. Only that mix shows whether the held request stays steady and whether the skip costs no cycle. Random operations therefore draw sparse predicates by combining several random words, toggle `reqReady` randomly, and drive random junk on the operation inputs with `opValid` pulsing while the block is busy. Directed operations cover the empty predicate, predicate bits that lie inside a lane's byte group but off its lowest byte, a 64-bit address wrap, a carry out of a 32-bit element, and full-throughput runs with `reqReady` tied high.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;      // capture operation fields and lane mask
    logic loadBase;  // capture the vector base (only if a lane is active)
    logic advance;   // retire the current lane
  } gpfStrobe_t;

  typedef struct packed {
    logic       write;
    logic [1:0] level;
    logic       stream;
  } gpfHint_t;

  function automatic gpfHint_t decodeHint(input logic [3:0] code);
    gpfHint_t h;
    h.write  = code[3];
    h.level  = code[2:1];
    h.stream = code[0];
    return h;
  endfunction

endpackage

// File: rtl/gpf_datapath.sv
module gpf_datapath
  import gpf_pkg::*;
#(
  parameter int VEC_BITS  = 256,
  parameter int PRED_BITS = VEC_BITS / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  gpfStrobe_t           strobe,
  input  logic [VEC_BITS-1:0]  opVector,
  input  logic [PRED_BITS-1:0] opPred,
  input  logic                 opWide,
  input  logic [4:0]           opImm,
  input  logic [3:0]           opCode,
  output logic                 anyIn,
  output logic                 lastLane,
  output logic [63:0]          reqAddr,
  output gpfHint_t             reqHint
);

  localparam int LANE32 = VEC_BITS / 32;
  localparam int LANE64 = VEC_BITS / 64;
  localparam int LIDX_W = $clog2(LANE32);
  localparam int WIDX_W = $clog2(LANE64);

  // Lane mask of the incoming operation: lowest predicate bit of each lane's byte group
  logic [LANE32-1:0] narrowMask;
  logic [LANE64-1:0] wideMask;
  logic [LANE32-1:0] maskIn;

  genvar g;
  generate
    for (g = 0; g < LANE32; g++) begin : gNarrowMask
      assign narrowMask[g] = opPred[g*4];
    end
    for (g = 0; g < LANE64; g++) begin : gWideMask
      assign wideMask[g] = opPred[g*8];
    end
  endgenerate

  assign maskIn = opWide ? LANE32'(wideMask) : narrowMask;
  assign anyIn  = |maskIn;

  // Registered operation state
  logic [LANE32-1:0]   pending;
  logic [VEC_BITS-1:0] baseReg;
  logic                wideReg;
  logic [7:0]          offsetReg;
  gpfHint_t            hintReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      wideReg   <= 1'b0;
      offsetReg <= '0;
      hintReg   <= '0;
    end else if (strobe.load) begin
      pending   <= maskIn;
      wideReg   <= opWide;
      offsetReg <= {opImm, 3'b000};
      hintReg   <= decodeHint(opCode);
    end else if (strobe.advance) begin
      pending   <= pending & (pending - LANE32'(1));  // clear lowest set lane
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.loadBase) baseReg <= opVector;
  end

  // Find-next-active: lowest pending lane
  logic [LIDX_W-1:0] curLane;
  always_comb begin
    curLane = '0;
    for (int i = LANE32 - 1; i >= 0; i--) begin
      if (pending[i]) curLane = LIDX_W'(i);
    end
  end

  assign lastLane = ((pending & (pending - LANE32'(1))) == '0);

  // Lane element views of the base vector
  logic [31:0] narrowArr [LANE32];
  logic [63:0] wideArr   [LANE64];
  generate
    for (g = 0; g < LANE32; g++) begin : gNarrowElem
      assign narrowArr[g] = baseReg[g*32 +: 32];
    end
    for (g = 0; g < LANE64; g++) begin : gWideElem
      assign wideArr[g] = baseReg[g*64 +: 64];
    end
  endgenerate

  logic [WIDX_W-1:0] wideIdx;
  logic [63:0]       laneElem;
  assign wideIdx  = curLane[WIDX_W-1:0];
  assign laneElem = wideReg ? wideArr[wideIdx] : {32'b0, narrowArr[curLane]};
  assign reqAddr  = laneElem + {56'b0, offsetReg};
  assign reqHint  = hintReg;

endmodule

// File: rtl/gpf_control.sv
module gpf_control
  import gpf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       opValid,
  input  logic       reqReady,
  input  logic       anyIn,
  input  logic       lastLane,
  output logic       opReady,
  output logic       reqValid,
  output logic       opDone,
  output gpfStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_FIN} gpfState_t;
  gpfState_t state, stateNext;

  logic accept, handshake;
  assign opReady   = (state == ST_IDLE);
  assign reqValid  = (state == ST_BUSY);
  assign opDone    = (state == ST_FIN);
  assign accept    = opReady && opValid;
  assign handshake = reqValid && reqReady;

  always_comb begin
    strobe          = '0;
    strobe.load     = accept;
    strobe.loadBase = accept && anyIn;
    strobe.advance  = handshake;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) stateNext = anyIn ? ST_BUSY : ST_FIN;
      ST_BUSY: if (handshake && lastLane) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

endmodule

// File: rtl/gpf_seq.sv
module gpf_seq
  import gpf_pkg::*;
#(
  parameter int VEC_BITS  = 256,
  parameter int PRED_BITS = VEC_BITS / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 opValid,
  output logic                 opReady,
  input  logic [VEC_BITS-1:0]  opVector,
  input  logic [PRED_BITS-1:0] opPred,
  input  logic                 opWide,
  input  logic [4:0]           opImm,
  input  logic [3:0]           opCode,
  output logic                 reqValid,
  input  logic                 reqReady,
  output logic [63:0]          reqAddr,
  output logic                 reqWrite,
  output logic [1:0]           reqLevel,
  output logic                 reqStream,
  output logic                 opDone
);

  gpfStrobe_t strobe;
  gpfHint_t   hint;
  logic       anyIn, lastLane;

  gpf_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opValid  (opValid),
    .reqReady (reqReady),
    .anyIn    (anyIn),
    .lastLane (lastLane),
    .opReady  (opReady),
    .reqValid (reqValid),
    .opDone   (opDone),
    .strobe   (strobe)
  );

  gpf_datapath #(.VEC_BITS(VEC_BITS), .PRED_BITS(PRED_BITS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .opVector (opVector),
    .opPred   (opPred),
    .opWide   (opWide),
    .opImm    (opImm),
    .opCode   (opCode),
    .anyIn    (anyIn),
    .lastLane (lastLane),
    .reqAddr  (reqAddr),
    .reqHint  (hint)
  );

  assign reqWrite  = hint.write;
  assign reqLevel  = hint.level;
  assign reqStream = hint.stream;

endmodule

// File: rtl/gpf_seq_chk.sv
module gpf_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        opValid,
  input logic        opReady,
  input logic        reqValid,
  input logic        reqReady,
  input logic [63:0] reqAddr,
  input logic        reqWrite,
  input logic [1:0]  reqLevel,
  input logic        reqStream,
  input logic        opDone
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqWrite)
                              && $stable(reqLevel) && $stable(reqStream)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    opDone |=> !opDone); // R7

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    opDone |-> !reqValid); // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    opReady |-> !reqValid && !opDone); // R8

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    opValid && opReady |=> !opReady); // R8

endmodule

bind gpf_seq gpf_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .opValid   (opValid),
  .opReady   (opReady),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqAddr   (reqAddr),
  .reqWrite  (reqWrite),
  .reqLevel  (reqLevel),
  .reqStream (reqStream),
  .opDone    (opDone)
);

// File: tb/sim_gpf_seq.sv
`timescale 1ns/1ps
module sim_gpf_seq;

  localparam int VEC_BITS  = 256;
  localparam int PRED_BITS = VEC_BITS / 8;
  localparam int LANE32    = VEC_BITS / 32;
  localparam int LANE64    = VEC_BITS / 64;

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 opValid;
  logic                 opReady;
  logic [VEC_BITS-1:0]  opVector;
  logic [PRED_BITS-1:0] opPred;
  logic                 opWide;
  logic [4:0]           opImm;
  logic [3:0]           opCode;
  logic                 reqValid;
  logic                 reqReady;
  logic [63:0]          reqAddr;
  logic                 reqWrite;
  logic [1:0]           reqLevel;
  logic                 reqStream;
  logic                 opDone;

  always #2 clk = ~clk;

  gpf_seq #(.VEC_BITS(VEC_BITS)) u0 (.*);

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  logic [63:0] expAddr [LANE32];
  int          expCnt;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // Reference model built from R1..R3
  task automatic buildExp(input logic [VEC_BITS-1:0] v, input logic [PRED_BITS-1:0] p,
                          input logic w, input logic [4:0] imm);
    int lanes;
    logic [63:0] elem;
    expCnt = 0;
    lanes = w ? LANE64 : LANE32;
    for (int i = 0; i < lanes; i++) begin
      if (p[w ? i*8 : i*4]) begin
        elem = w ? v[i*64 +: 64] : {32'b0, v[i*32 +: 32]};
        expAddr[expCnt] = elem + {56'b0, imm, 3'b000};
        expCnt++;
      end
    end
  endtask

  function automatic logic [VEC_BITS-1:0] randVec();
    logic [VEC_BITS-1:0] v;
    for (int k = 0; k < VEC_BITS/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [PRED_BITS-1:0] randPred();
    logic [PRED_BITS-1:0] p;
    int mode;
    mode = $urandom % 3;
    p = PRED_BITS'($urandom);
    if (mode == 1) p = p & PRED_BITS'($urandom);
    if (mode == 2) p = p & PRED_BITS'($urandom) & PRED_BITS'($urandom);
    return p;
  endfunction

  // Drive one operation, then check every request and the done pulse.
  // fullReady: reqReady tied high (R10); otherwise random back-pressure.
  task automatic runOp(input logic [VEC_BITS-1:0] v, input logic [PRED_BITS-1:0] p,
                       input logic w, input logic [4:0] imm, input logic [3:0] code,
                       input bit fullReady);
    int idx;
    bit hs;
    buildExp(v, p, w, imm);
    @(negedge clk);
    opValid = 1'b1; opVector = v; opPred = p; opWide = w; opImm = imm; opCode = code;
    chk(opReady === 1'b1, "R8 idle ready", 64'(opReady), 64'd1);
    @(posedge clk);
    @(negedge clk);
    // scramble inputs after acceptance (R8)
    opValid = 1'b0; opVector = randVec(); opPred = PRED_BITS'($urandom);
    opWide = 1'($urandom); opImm = 5'($urandom); opCode = 4'($urandom);
    if (expCnt == 0) begin
      chk(opDone === 1'b1 && reqValid === 1'b0, "R7 empty done", {62'b0, opDone, reqValid}, 64'd2);
      chk(opReady === 1'b0, "R8 ready low in done", 64'(opReady), 64'd0);
    end else begin
      idx = 0;
      while (idx < expCnt) begin
        reqReady = fullReady ? 1'b1 : 1'($urandom);
        opValid  = 1'($urandom);
        opVector = randVec();
        opPred   = PRED_BITS'($urandom);
        opWide   = 1'($urandom);
        opImm    = 5'($urandom);
        opCode   = 4'($urandom);
        #0.5;
        chk(opReady === 1'b0, "R8 ready low when busy", 64'(opReady), 64'd0);
        chk(reqValid === 1'b1, fullReady ? "R10 valid every cycle" : "R6 valid held",
            64'(reqValid), 64'd1);
        chk(reqAddr === expAddr[idx], w ? "R1 R2 R4 wide address" : "R1 R3 R4 narrow address",
            reqAddr, expAddr[idx]);
        chk({reqWrite, reqLevel, reqStream} === code, "R5 hint",
            64'({reqWrite, reqLevel, reqStream}), 64'(code));
        chk(opDone === 1'b0, "R7 no done mid-op", 64'(opDone), 64'd0);
        hs = reqValid && reqReady;
        @(posedge clk);
        if (hs) idx++;
        @(negedge clk);
      end
      opValid = 1'b0;
      reqReady = 1'($urandom);
      #0.5;
      chk(opDone === 1'b1 && reqValid === 1'b0, "R7 done after last", {62'b0, opDone, reqValid}, 64'd2);
    end
    @(posedge clk);
    @(negedge clk);
    chk(opDone === 1'b0 && opReady === 1'b1, "R7 R8 back to idle", {62'b0, opDone, opReady}, 64'd1);
    chk(reqValid === 1'b0, "R3 no extra request", 64'(reqValid), 64'd0);
  endtask

  initial begin
    logic [VEC_BITS-1:0] v;
    logic [PRED_BITS-1:0] p;
    void'($urandom(32'd20240611));
    rst = 1'b1; opValid = 1'b0; reqReady = 1'b0;
    opVector = '0; opPred = '0; opWide = 1'b0; opImm = '0; opCode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(opReady === 1'b1 && reqValid === 1'b0 && opDone === 1'b0, "R9 reset state",
        {61'b0, opReady, reqValid, opDone}, 64'd4);

    // R3: no active lane, but off-group bits set
    runOp(randVec(), {PRED_BITS/4{4'b1110}}, 1'b0, 5'd3, 4'b1011, 1'b0);
    // R3 wide: bits at multiples of 4 but not 8 are ignored
    runOp(randVec(), {PRED_BITS/8{8'b0001_0000}}, 1'b1, 5'd9, 4'b0100, 1'b1);
    // R1 wrap on 64-bit lanes, all active, imm max, R10 full rate
    runOp({VEC_BITS{1'b1}}, '1, 1'b1, 5'd31, 4'b1111, 1'b1);
    // R1 carry out of 32-bit element
    v = randVec(); v[31:0] = 32'hFFFF_FFFF;
    runOp(v, PRED_BITS'(1), 1'b0, 5'd31, 4'b0001, 1'b0);
    // R4 R10 sparse: first and last narrow lanes only
    p = '0; p[0] = 1'b1; p[(LANE32-1)*4] = 1'b1;
    runOp(randVec(), p, 1'b0, 5'd1, 4'b0010, 1'b1);
    // last wide lane only
    p = '0; p[(LANE64-1)*8] = 1'b1;
    runOp(randVec(), p, 1'b1, 5'd0, 4'b1000, 1'b0);

    for (int n = 0; n < 200; n++) begin
      runOp(randVec(), randPred(), 1'($urandom), 5'($urandom), 4'($urandom), ($urandom % 4) == 0);
    end
    finishRun();
  end

endmodule